// File: doc/BRIEF.md
# Pseudo-Chaotic Chip Generator

This block produces a binary spreading chip stream for a direct-sequence transmitter or receiver. The generator is not a linear shift register. It keeps four cells in a chain. Each cell holds an upper word and a lower word, and its output word is their bitwise XOR. On every step the output words move one cell down the chain, and the last cell's word wraps round to the first cell. The lower words shift left, and each passes its top bit back into the cell before it. The chip is the parity of the last cell's output word, and that same bit is fed back into the last cell's lower word.

Software or a control engine seeds all sixty-four state bits through a narrow write port: a strobe, a register select and an 8-bit value. Once every register has been written at least once, the block reports that it is ready. From then on, each clock cycle with the run input high advances the state by one step and delivers one chip. A small state machine has three states. SEED waits for the loaded mask to fill. IDLE means the block is seeded and did not step in the last cycle. RUN means the last cycle produced a chip. The transitions are:
- SEED→IDLE when the last missing register is written.
- IDLE→RUN on a step cycle.
- RUN→IDLE on a cycle without a step.
- RUN→RUN and IDLE→IDLE otherwise.

Top module: `pcs_chip_gen`

## Requirements
- R1: After reset, ready_o is 0, chip_valid_o is 0, chip_o is 0, and no register counts as loaded.
- R2: A cycle with load_i high writes init_i into the register chosen by sel_i. Select value 2c picks the upper word of cell c, and select value 2c+1 picks the lower word of cell c. Cell 0 is the first cell and cell 3 is the last.
- R3: ready_o rises in the cycle after the eighth distinct select value has been written. Writing the same select value again does not count as a new register. Once high, ready_o stays high until reset.
- R4: Before ready_o is high, run_i is ignored: no chip_valid_o pulse appears and the seeded state is kept.
- R5: A cell's output word is its upper word XOR its lower word. The chip is the XOR of all eight bits of the last cell's output word.
- R6: On a step, the upper word of cell c (c>0) takes the output word of cell c-1, and the upper word of cell 0 takes the output word of cell 3.
- R7: On a step, every lower word shifts left by one. The LSB of the lower word of cell c (c<3) takes the old MSB of the lower word of cell c+1. The LSB of the lower word of cell 3 takes the chip. The old MSB of the lower word of cell 0 is dropped.
- R8: A step happens on each clock edge where ready_o, run_i and !load_i are all high. In the following cycle, chip_valid_o is 1 and chip_o holds the chip of the state before that step.
- R9: When run_i is low, or load_i is high, no step happens. chip_valid_o is then 0 in the next cycle, and chip_o keeps its last value.
- R10: Writing a register after ready_o is high replaces that word, and the next step uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Seed write strobe |
| sel_i | input | 3 | Register select (2c = upper, 2c+1 = lower of cell c) |
| init_i | input | 8 | Seed value |
| run_i | input | 1 | Step enable |
| ready_o | output | 1 | All registers seeded |
| chip_o | output | 1 | Latest chip |
| chip_valid_o | output | 1 | chip_o was produced on the previous edge |

## Verification
The hardest cases come from the bit coupling between cells. A wrong wrap-around or a wrong neighbour direction only shows up after the lower words have shifted several places, so short runs would not reveal it. The bench therefore runs more than 512 steps from each of two different seed sets. It compares every chip against a reference model of the stepping rule. Two further cases sit inside a running stream: a reseed during a pause, and a cycle where load and run are high together. Each must leave the stream aligned with the model. The bench also drives run before seeding is complete and rewrites one register twice, to show that ready waits for all distinct registers.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int unsigned WORD_W    = 8;
    localparam int unsigned NUM_CELLS = 4;
    localparam int unsigned NUM_REGS  = 2 * NUM_CELLS;
    localparam int unsigned SEL_W     = $clog2(NUM_REGS);

    typedef enum logic [1:0] {
        ST_SEED = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_t;
endpackage

// File: rtl/pcs_cell.sv
module pcs_cell #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         ld_up_i,
    input  logic         ld_lo_i,
    input  logic [W-1:0] init_i,
    input  logic [W-1:0] up_next_i,
    input  logic         lsb_in_i,
    output logic [W-1:0] out_o,
    output logic         msb_o
);
    logic [W-1:0] up_q;
    logic [W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= '0;
        end else if (ld_up_i) begin
            up_q <= init_i;
        end else if (step_i) begin
            up_q <= up_next_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (ld_lo_i) begin
            lo_q <= init_i;
        end else if (step_i) begin
            lo_q <= {lo_q[W-2:0], lsb_in_i};
        end
    end

    assign out_o = up_q ^ lo_q;
    assign msb_o = lo_q[W-1];
endmodule

// File: rtl/pcs_seed_ctrl.sv
module pcs_seed_ctrl
    import pcs_pkg::*;
#(
    parameter int unsigned NREG = NUM_REGS,
    localparam int unsigned SW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [SW-1:0]   sel_i,
    input  logic            run_i,
    output logic [NREG-1:0] wr_en_o,
    output logic            step_o,
    output logic            ready_o,
    output logic            valid_o
);
    gen_state_t      state_q, state_d;
    logic [NREG-1:0] mask_q;
    logic [NREG-1:0] wr_en;

    for (genvar r = 0; r < NREG; r++) begin : g_dec
        assign wr_en[r] = load_i && (sel_i == SW'(r));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_q | wr_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        step_o  = 1'b0;
        unique case (state_q)
            ST_SEED: begin
                if (&(mask_q | wr_en)) state_d = ST_IDLE;
            end
            ST_IDLE, ST_RUN: begin
                step_o  = run_i && !load_i;
                state_d = step_o ? ST_RUN : ST_IDLE;
            end
            default: state_d = ST_SEED;
        endcase
    end

    always_comb begin
        wr_en_o = wr_en;
        ready_o = (state_q != ST_SEED);
        valid_o = (state_q == ST_RUN);
    end
endmodule

// File: rtl/pcs_chip_gen.sv
module pcs_chip_gen
    import pcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [WORD_W-1:0] init_i,
    input  logic             run_i,
    output logic             ready_o,
    output logic             chip_o,
    output logic             chip_valid_o
);
    logic [NUM_REGS-1:0] wr_en;
    logic                step;
    logic [WORD_W-1:0]   cell_out [NUM_CELLS];
    logic                cell_msb [NUM_CELLS];
    logic                chip_now;
    logic                chip_q;

    pcs_seed_ctrl #(.NREG(NUM_REGS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .sel_i   (sel_i),
        .run_i   (run_i),
        .wr_en_o (wr_en),
        .step_o  (step),
        .ready_o (ready_o),
        .valid_o (chip_valid_o)
    );

    assign chip_now = ^cell_out[NUM_CELLS-1];

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        logic [WORD_W-1:0] up_next;
        logic              lsb_in;
        if (c == 0) begin : g_head
            assign up_next = cell_out[NUM_CELLS-1];
        end else begin : g_body
            assign up_next = cell_out[c-1];
        end
        if (c == NUM_CELLS-1) begin : g_tail
            assign lsb_in = chip_now;
        end else begin : g_link
            assign lsb_in = cell_msb[c+1];
        end
        pcs_cell #(.W(WORD_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_i    (step),
            .ld_up_i   (wr_en[2*c]),
            .ld_lo_i   (wr_en[2*c+1]),
            .init_i    (init_i),
            .up_next_i (up_next),
            .lsb_in_i  (lsb_in),
            .out_o     (cell_out[c]),
            .msb_o     (cell_msb[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_q <= 1'b0;
        end else if (step) begin
            chip_q <= chip_now;
        end
    end

    assign chip_o = chip_q;
endmodule

// File: rtl/pcs_chip_gen_chk.sv
module pcs_chip_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic load_i,
    input logic run_i,
    input logic ready_o,
    input logic chip_o,
    input logic chip_valid_o
);
    AST_NO_CHIP_UNSEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> !chip_valid_o); // R4
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o); // R3
    AST_VALID_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid_o |-> $past(run_i && !load_i)); // R8
    AST_CHIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_valid_o |-> $stable(chip_o)); // R9
    AST_LOAD_BLOCKS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !chip_valid_o); // R9
endmodule

bind pcs_chip_gen pcs_chip_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .run_i        (run_i),
    .ready_o      (ready_o),
    .chip_o       (chip_o),
    .chip_valid_o (chip_valid_o)
);

// File: tb/pcs_chip_gen_tb.sv
module pcs_chip_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [2:0] sel_i = '0;
    logic [7:0] init_i = '0;
    logic       run_i = 1'b0;
    logic       ready_o, chip_o, chip_valid_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] mu [4];
    logic [7:0] ml [4];
    logic       exp_q [$];

    pcs_chip_gen u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .sel_i(sel_i),
        .init_i(init_i), .run_i(run_i), .ready_o(ready_o),
        .chip_o(chip_o), .chip_valid_o(chip_valid_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic model_chip();
        return ^(mu[3] ^ ml[3]);
    endfunction

    // R5 R6 R7: reference stepping rule
    task automatic model_step();
        logic [7:0] o [4];
        logic [7:0] nl [4];
        logic ch;
        for (int c = 0; c < 4; c++) o[c] = mu[c] ^ ml[c];
        ch = ^o[3];
        for (int c = 0; c < 4; c++)
            nl[c] = {ml[c][6:0], (c == 3) ? ch : ml[c+1][7]};
        mu[0] = o[3];
        for (int c = 1; c < 4; c++) mu[c] = o[c-1];
        for (int c = 0; c < 4; c++) ml[c] = nl[c];
    endtask

    // R2: select 2c = upper, 2c+1 = lower of cell c
    task automatic do_load(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk);
        load_i = 1'b1; sel_i = s; init_i = v;
        if (s[0]) ml[s[2:1]] = v; else mu[s[2:1]] = v;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic seed_all(input logic [63:0] seed);
        for (int r = 0; r < 8; r++) do_load(3'(r), seed[8*r +: 8]);
    endtask

    // driver: one expected chip per step cycle
    task automatic run_chips(input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            run_i = 1'b1;
            exp_q.push_back(model_chip());
            model_step();
            @(negedge clk);
        end
        run_i = 1'b0;
        @(negedge clk);
        check("R8 all chips delivered", exp_q.size() == 0, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int c = 0; c < 4; c++) begin mu[c] = '0; ml[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && chip_valid_o) begin
                if (exp_q.size() == 0) begin
                    check("R4/R9 unexpected chip_valid", 1'b1, 1'b0);
                end else begin
                    check("R8 chip stream", chip_o, exp_q.pop_front());
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic held;
        do_reset();
        // R1 reset state
        check("R1 ready after reset", ready_o, 1'b0);
        check("R1 valid after reset", chip_valid_o, 1'b0);
        check("R1 chip after reset", chip_o, 1'b0);

        // R3: seven distinct selects, one repeated, not ready
        do_load(3'd0, 8'h5A); do_load(3'd1, 8'h3C); do_load(3'd2, 8'hA7);
        do_load(3'd3, 8'h19); do_load(3'd4, 8'hE2); do_load(3'd5, 8'h6B);
        do_load(3'd6, 8'h04); do_load(3'd6, 8'hC8);
        check("R3 not ready with 7 of 8", ready_o, 1'b0);
        // R4: run before ready has no effect
        @(negedge clk); run_i = 1'b1;
        repeat (5) @(negedge clk);
        run_i = 1'b0;
        check("R4 still not ready", ready_o, 1'b0);
        check("R4 no chip before ready", chip_valid_o, 1'b0);
        do_load(3'd7, 8'h91);
        check("R3 ready after eighth register", ready_o, 1'b1);

        // seed set A, R5 R6 R7 R8 through the model
        run_chips(300);
        held = chip_o;
        repeat (6) @(negedge clk);
        check("R9 chip held while idle", chip_o, held);
        check("R9 no valid while idle", chip_valid_o, 1'b0);
        // R10: reseed one word after ready, no run
        do_load(3'd3, 8'hF0);
        check("R3 ready kept after reload", ready_o, 1'b1);
        check("R9 chip held across reload", chip_o, held);
        // R9: load and run together must not step
        @(negedge clk);
        run_i = 1'b1; load_i = 1'b1; sel_i = 3'd6; init_i = 8'h2D; mu[3] = 8'h2D;
        @(negedge clk);
        load_i = 1'b0; run_i = 1'b0;
        check("R9 no step with load", chip_valid_o, 1'b0);
        run_chips(300);

        // seed set B after reset
        do_reset();
        check("R1 ready cleared by reset", ready_o, 1'b0);
        seed_all(64'h0123_4567_89AB_CDEF);
        check("R3 ready for set B", ready_o, 1'b1);
        run_chips(260);
        run_chips(260);

        // all-zero seeds give zero chips
        do_reset();
        seed_all(64'h0);
        run_chips(40);

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule